// File: doc/BRIEF.md
# Programmable Receive Gain Stage

This block scales one stream of signed 16-bit linear voice samples on the receive side by a gain chosen from an 8-bit code. Each nonzero code gives a linear factor of (256 + 3 × code) / 1024. This factor runs from just above one quarter up to almost unity, so the path only ever attenuates. A code of zero does not give zero gain in the normal sense. It is a mute, and every sample presented while muted leaves the block as exact silence (0).

The code is held in a register inside the block. A single-cycle write strobe loads that register from a code input. Two fixed default codes are also available. A strap-load pulse copies one of them into the register, and a pin-strap level chooses which one. Reset clears the register, so the path starts muted. A small two-state controller follows the register. **MUTED** holds while the code is zero. **SCALING** holds otherwise. Transition **T_UNMUTE** (MUTED → SCALING) fires when a write or strap load brings a nonzero code. Transition **T_MUTE** (SCALING → MUTED) fires when a write brings code zero. Reset forces MUTED.

Each accepted sample is scaled with the code held in the register at that moment. The result appears on the output, with its strobe, one clock later.

Top module: `rxg_gain_stage`

## Requirements
- R1: After reset the gain code is 00h, `out_valid` is 0 and `out_sample` is 0, so the first sample after reset is muted.
- R2: A sample accepted while the code is 00h produces `out_sample` = 0, with `out_valid` asserted.
- R3: A sample x accepted with nonzero code c produces floor(x × (256 + 3c) / 1024), saturated to the signed 16-bit range.
- R4: A strap-load pulse with `strap_lvl` = 1 loads code E2h. A sample of 1024 then yields 934.
- R5: A strap-load pulse with `strap_lvl` = 0 loads code AFh. A sample of 1024 then yields 781.
- R6: `out_valid` is exactly `in_valid` delayed by one clock.
- R7: A code written in the same cycle as an accepted sample does not apply to that sample. It applies from the next accepted sample on.
- R8: When `strap_load` and `cfg_we` are both high in one cycle, the strap default wins and the written code is discarded.
- R9: While `in_valid` is low, `out_sample` keeps its last value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input sample strobe |
| in_sample | input | 16 | Signed linear input sample |
| cfg_we | input | 1 | Gain code write strobe |
| cfg_code | input | 8 | Gain code to write |
| strap_lvl | input | 1 | Pin-strap level that selects the default code |
| strap_load | input | 1 | Pulse that loads the strap-selected default |
| out_valid | output | 1 | Output sample strobe |
| out_sample | output | 16 | Signed scaled output sample |

## Verification
The bench builds the block with its default parameters: 16-bit samples, 8-bit codes, a 10-bit fractional shift and the two default strap codes. With these values the whole code range is in reach, from the smallest step (01h) to full scale (FFh), including the mute code. Negative samples whose products have a remainder show the rounding toward minus infinity, and the two extreme sample values show the ends of the output range. The default codes can be told apart at the ports through a fixed probe sample of 1024.

// File: rtl/rxg_pkg.sv
package rxg_pkg;

    // Controller state of the gain code register
    typedef enum logic [0:0] {
        RXG_MUTED   = 1'b0,
        RXG_SCALING = 1'b1
    } rxg_state_e;

    localparam int RXG_DATA_W   = 16;
    localparam int RXG_CODE_W   = 8;
    localparam int RXG_FRAC_W   = 10;
    localparam int RXG_BASE     = 256;
    localparam int RXG_SLOPE    = 3;
    localparam logic [7:0] RXG_STRAP_HI = 8'hE2;
    localparam logic [7:0] RXG_STRAP_LO = 8'hAF;

endpackage

// File: rtl/rxg_code_reg.sv
module rxg_code_reg
    import rxg_pkg::*;
#(
    parameter int              CODE_W   = RXG_CODE_W,
    parameter logic [CODE_W-1:0] STRAP_HI = CODE_W'(RXG_STRAP_HI),
    parameter logic [CODE_W-1:0] STRAP_LO = CODE_W'(RXG_STRAP_LO)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [CODE_W-1:0] wr_code,
    input  logic              strap_lvl,
    input  logic              strap_load,
    output logic [CODE_W-1:0] code,
    output rxg_state_e        state
);

    logic [CODE_W-1:0] code_q, code_d;
    rxg_state_e        state_q, state_d;
    logic              load_any;
    logic [CODE_W-1:0] strap_code;

    assign strap_code = strap_lvl ? STRAP_HI : STRAP_LO;
    assign load_any   = strap_load | wr_en;

    // Next code: the strap default has priority over a write
    always_comb begin
        code_d = code_q;
        if (strap_load) begin
            code_d = strap_code;
        end else if (wr_en) begin
            code_d = wr_code;
        end
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RXG_MUTED: begin
                if (load_any && (code_d != '0)) state_d = RXG_SCALING;   // T_UNMUTE
            end
            RXG_SCALING: begin
                if (load_any && (code_d == '0)) state_d = RXG_MUTED;     // T_MUTE
            end
            default: state_d = RXG_MUTED;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= RXG_MUTED;
            code_q  <= '0;
        end else begin
            state_q <= state_d;
            code_q  <= code_d;
        end
    end

    // Outputs
    always_comb begin
        code  = code_q;
        state = state_q;
    end

    AST_STRAP_DEFAULT: assert property (@(posedge clk) disable iff (!rst_n)
        strap_load |=> (code_q == ($past(strap_lvl) ? STRAP_HI : STRAP_LO))); // R4

    AST_STRAP_BEATS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (strap_load && wr_en && (wr_code != strap_code)) |=> (code_q != $past(wr_code))); // R8

    AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !strap_load) |=> (code_q == $past(wr_code))); // R7

    AST_STATE_TRACKS: assert property (@(posedge clk) disable iff (!rst_n)
        load_any |=> ((state_q == RXG_MUTED) == (code_q == '0))); // R2

endmodule

// File: rtl/rxg_scaler.sv
module rxg_scaler
    import rxg_pkg::*;
#(
    parameter int DATA_W = RXG_DATA_W,
    parameter int CODE_W = RXG_CODE_W,
    parameter int FRAC_W = RXG_FRAC_W,
    parameter int BASE   = RXG_BASE,
    parameter int SLOPE  = RXG_SLOPE
) (
    input  logic signed [DATA_W-1:0] sample,
    input  logic        [CODE_W-1:0] code,
    output logic signed [DATA_W-1:0] scaled
);

    localparam int FACT_MAX = BASE + SLOPE * ((1 << CODE_W) - 1);
    localparam int FACT_W   = $clog2(FACT_MAX + 1);
    localparam int PROD_W   = DATA_W + FACT_W + 1;
    localparam logic signed [PROD_W-1:0] MAX_V =
        $signed({{(PROD_W-DATA_W+1){1'b0}}, {(DATA_W-1){1'b1}}});
    localparam logic signed [PROD_W-1:0] MIN_V = ~MAX_V;

    logic        [FACT_W-1:0] factor;
    logic signed [PROD_W-1:0] samp_ext, fact_ext, prod, shifted;

    // Factor (BASE + SLOPE*code) in units of 2^-FRAC_W
    assign factor   = FACT_W'(BASE) + FACT_W'(SLOPE) * FACT_W'(code);
    assign samp_ext = PROD_W'(sample);
    assign fact_ext = $signed({{(PROD_W-FACT_W){1'b0}}, factor});
    assign prod     = samp_ext * fact_ext;
    // Arithmetic shift rounds toward minus infinity
    assign shifted  = prod >>> FRAC_W;

    always_comb begin
        if (shifted > MAX_V) begin
            scaled = MAX_V[DATA_W-1:0];
        end else if (shifted < MIN_V) begin
            scaled = MIN_V[DATA_W-1:0];
        end else begin
            scaled = shifted[DATA_W-1:0];
        end
    end

endmodule

// File: rtl/rxg_gain_stage.sv
module rxg_gain_stage
    import rxg_pkg::*;
#(
    parameter int DATA_W = RXG_DATA_W,
    parameter int CODE_W = RXG_CODE_W,
    parameter int FRAC_W = RXG_FRAC_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_sample,
    input  logic              cfg_we,
    input  logic [CODE_W-1:0] cfg_code,
    input  logic              strap_lvl,
    input  logic              strap_load,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_sample
);

    logic [CODE_W-1:0]        code;
    rxg_state_e               state;
    logic signed [DATA_W-1:0] scaled;
    logic                     vld_q;
    logic [DATA_W-1:0]        smp_q, smp_d;

    rxg_code_reg #(
        .CODE_W  (CODE_W),
        .STRAP_HI(CODE_W'(RXG_STRAP_HI)),
        .STRAP_LO(CODE_W'(RXG_STRAP_LO))
    ) u_code (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (cfg_we),
        .wr_code   (cfg_code),
        .strap_lvl (strap_lvl),
        .strap_load(strap_load),
        .code      (code),
        .state     (state)
    );

    rxg_scaler #(
        .DATA_W(DATA_W),
        .CODE_W(CODE_W),
        .FRAC_W(FRAC_W),
        .BASE  (RXG_BASE),
        .SLOPE (RXG_SLOPE)
    ) u_scale (
        .sample($signed(in_sample)),
        .code  (code),
        .scaled(scaled)
    );

    // Output select driven by the controller state
    always_comb begin
        smp_d = smp_q;
        if (in_valid) begin
            unique case (state)
                RXG_MUTED:   smp_d = '0;
                RXG_SCALING: smp_d = scaled;
                default:     smp_d = '0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vld_q <= 1'b0;
            smp_q <= '0;
        end else begin
            vld_q <= in_valid;
            smp_q <= smp_d;
        end
    end

    assign out_valid  = vld_q;
    assign out_sample = smp_q;

    AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid); // R6
    AST_VALID_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid); // R6
    AST_MUTE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (code == '0)) |=> (out_sample == '0)); // R2
    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(out_sample)); // R9

endmodule

// File: tb/rxg_gain_stage_tb.sv
`timescale 1ns/1ps
module rxg_gain_stage_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [15:0] in_sample = '0;
    logic        cfg_we = 1'b0;
    logic [7:0]  cfg_code = '0;
    logic        strap_lvl = 1'b0;
    logic        strap_load = 1'b0;
    logic        out_valid;
    logic [15:0] out_sample;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2 clk = ~clk;

    rxg_gain_stage u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sample(in_sample),
        .cfg_we(cfg_we), .cfg_code(cfg_code), .strap_lvl(strap_lvl),
        .strap_load(strap_load), .out_valid(out_valid), .out_sample(out_sample)
    );

    // {code, sample}
    localparam logic [23:0] VEC [10] = '{
        {8'h01, 16'd1000},
        {8'h80, 16'hFFFD},
        {8'hFF, 16'h8000},
        {8'hFF, 16'h7FFF},
        {8'h00, 16'd12345},
        {8'h40, 16'hFFFF},
        {8'hAA, 16'd20000},
        {8'h10, 16'hB1E0},
        {8'hE2, 16'd1},
        {8'h55, 16'h8001}
    };

    function automatic logic [15:0] model(logic [7:0] c, logic [15:0] s);
        longint p;
        if (c == 8'h00) return 16'h0000;
        p = longint'($signed(s)) * longint'(256 + 3 * int'(c));
        p = p >>> 10;
        if (p > 32767) p = 32767;
        if (p < -32768) p = -32768;
        return 16'(p);
    endfunction

    task automatic check(string req, logic [15:0] act, logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0d (%h) expected %0d (%h)", req,
                     $signed(act), act, $signed(exp), exp);
        end
    endtask

    task automatic write_code(logic [7:0] c);
        @(negedge clk); cfg_we = 1'b1; cfg_code = c;
        @(negedge clk); cfg_we = 1'b0;
    endtask

    task automatic strap(logic lvl);
        @(negedge clk); strap_lvl = lvl; strap_load = 1'b1;
        @(negedge clk); strap_load = 1'b0;
    endtask

    // Send one sample; result is visible at the following falling edge
    task automatic send(logic [15:0] s);
        @(negedge clk); in_valid = 1'b1; in_sample = s;
        @(negedge clk); in_valid = 1'b0;
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            finish_run();
        end
    end

    initial begin
        logic [15:0] held;
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1 out_valid reset", {15'd0, out_valid}, 16'd1 - 16'd1);
        check("R1 out_sample reset", out_sample, 16'h0000);
        rst_n = 1'b1;
        send(16'd5000);
        check("R1 first sample muted", out_sample, 16'h0000);
        check("R2/R6 valid with mute", {15'd0, out_valid}, 16'd1);

        // Table walk: R3 and R2
        for (int i = 0; i < 10; i++) begin
            write_code(VEC[i][23:16]);
            send(VEC[i][15:0]);
            check(VEC[i][23:16] == 8'h00 ? "R2 mute vector" : "R3 gain vector",
                  out_sample, model(VEC[i][23:16], VEC[i][15:0]));
        end

        // R6 / R9: idle cycle
        held = out_sample;
        @(negedge clk);
        check("R6 valid drops", {15'd0, out_valid}, 16'd0);
        check("R9 sample held", out_sample, held);
        repeat (3) @(negedge clk);
        check("R9 sample held long", out_sample, held);

        // R4 / R5: strap defaults
        strap(1'b1);
        send(16'd1024);
        check("R4 strap high", out_sample, 16'd934);
        strap(1'b0);
        send(16'd1024);
        check("R5 strap low", out_sample, 16'd781);

        // R7: write in same cycle as sample
        write_code(8'h80);
        @(negedge clk);
        in_valid = 1'b1; in_sample = 16'd2048; cfg_we = 1'b1; cfg_code = 8'hFF;
        @(negedge clk);
        in_valid = 1'b0; cfg_we = 1'b0;
        check("R7 old code used", out_sample, model(8'h80, 16'd2048));
        send(16'd2048);
        check("R7 new code next", out_sample, model(8'hFF, 16'd2048));

        // R7: write of mute concurrent with sample
        @(negedge clk);
        in_valid = 1'b1; in_sample = 16'd4000; cfg_we = 1'b1; cfg_code = 8'h00;
        @(negedge clk);
        in_valid = 1'b0; cfg_we = 1'b0;
        check("R7 mute not yet", out_sample, model(8'hFF, 16'd4000));
        send(16'd4000);
        check("R7 mute next sample", out_sample, 16'h0000);

        // R8: strap beats write
        @(negedge clk);
        strap_lvl = 1'b1; strap_load = 1'b1; cfg_we = 1'b1; cfg_code = 8'h01;
        @(negedge clk);
        strap_load = 1'b0; cfg_we = 1'b0;
        send(16'd1024);
        check("R8 strap priority", out_sample, 16'd934);

        // R1: reset again clears the code
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk);
        check("R1 reset clears output", out_sample, 16'h0000);
        rst_n = 1'b1;
        send(16'd1024);
        check("R1 code cleared by reset", out_sample, 16'h0000);

        done = 1;
        finish_run();
    end

endmodule